// File: doc/BRIEF.md
# Jump Page and Skip Control

This block sits beside the decoder of a small 8-bit core. It holds the state that extends jump and call addresses and the state that makes the core skip an instruction. A three-bit page field is loaded by a page instruction. It is joined above the 13-bit address field of a jump or call to form a 16-bit target. A skip state, once entered, squashes the next instruction that retires.

The skip state can also be carried across a subroutine return. Software parks the wanted skip decision in a skip-after-return bit. A return of the ordinary kind consumes that bit: it enters the skip state when the bit is 1, and it clears the bit either way. A return from interrupt clears the bit but ignores its value. On interrupt entry the live skip state is copied into a shadow flag, so the handler can see that it interrupted a skip. The skip state itself is kept, and the first handler instruction absorbs it.

The status byte is laid out as follows: bits 7..5 hold the page, bit 4 skip-after-return, bit 3 the shadow flag, bit 2 Z, bit 1 DC and bit 0 C.

Top module: `pgskip_ctl`

## Requirements
- R1: After reset, `status` is 8'h00 and `squash` is 0.
- R2: An executed page instruction (`page_en`) loads `page_val` into `status[7:5]` at the next edge and leaves bits 4..0 unchanged. Otherwise the page changes only through a status write.
- R3: `jump_target` always equals {`status[7:5]`, `addr_in`}. `jump_take` is 1 exactly when `instr_valid` is 1, `jmp_en` or `call_en` is 1, `squash` is 0 and `irq_entry` is 0.
- R4: An executed instruction with `skip_take` set raises `squash` at the next edge. `squash` then stays 1 over cycles in which no instruction retires.
- R5: An instruction that retires while `squash` is 1 has no effect on `status`, whatever its strobes. `squash` is 0 after it.
- R6: An executed `ret_en` sets `squash` to the prior value of `status[4]` and clears `status[4]`.
- R7: An executed `reti_en` clears `status[4]` and leaves `squash` at 0, even when `status[4]` was 1.
- R8: In an `irq_entry` cycle, `status[3]` takes the current `squash` and `squash` keeps its value. All instruction strobes in that cycle are ignored.
- R9: An executed status write (`st_we`) loads all eight bits from `st_wdata`. It overrides a page or flag update in the same cycle, and it is how software clears `status[3]`.
- R10: An executed flag update (`flag_we`) loads `flag_in` into `status[2:0]` and leaves bits 7..3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| page_en | input | 1 | Page instruction |
| page_val | input | 3 | New page value |
| jmp_en | input | 1 | Jump instruction |
| call_en | input | 1 | Call instruction |
| addr_in | input | 13 | Address field of jump or call |
| skip_take | input | 1 | Skip instruction whose condition holds |
| ret_en | input | 1 | Ordinary return (consumes skip-after-return) |
| reti_en | input | 1 | Return from interrupt |
| irq_entry | input | 1 | Interrupt entry cycle |
| st_we | input | 1 | Status register write |
| st_wdata | input | 8 | Status write data |
| flag_we | input | 1 | ALU flag update |
| flag_in | input | 3 | New Z, DC, C |
| jump_target | output | 16 | Paged jump or call target |
| jump_take | output | 1 | Jump or call takes effect |
| squash | output | 1 | Current instruction is skipped |
| status | output | 8 | Status byte |

## Verification
The bench squashes an instruction that carries every strobe at once. A design that let any of them through would change the page, the flags or the skip state. Ordinary returns are run with the skip-after-return bit both set and clear, and a return from interrupt is run with the bit set. A design that treated the two kinds of return alike would skip after the return from interrupt or leave the bit set. Interrupt entry is tested both during a skip and outside one, with a page strobe present in the same cycle. A design that cleared the skip on entry, or that let the strobe act, shows the wrong shadow flag, the wrong squash or the wrong page. Same-cycle status and flag writes check which update wins.

// File: rtl/pgskip_ctl.sv
module pgskip_ctl #(
  parameter int PW = 3,
  parameter int AW = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic               page_en,
  input  logic [PW-1:0]      page_val,
  input  logic               jmp_en,
  input  logic               call_en,
  input  logic [AW-1:0]      addr_in,
  input  logic               skip_take,
  input  logic               ret_en,
  input  logic               reti_en,
  input  logic               irq_entry,
  input  logic               st_we,
  input  logic [7:0]         st_wdata,
  input  logic               flag_we,
  input  logic [2:0]         flag_in,
  output logic [PW+AW-1:0]   jump_target,
  output logic               jump_take,
  output logic               squash,
  output logic [7:0]         status
);
  logic [PW-1:0] page_q;
  logic          sar_q, ssf_q, skip_q;
  logic [2:0]    flg_q;
  logic          exec;

  assign exec        = instr_valid & ~irq_entry & ~skip_q;
  assign squash      = skip_q;
  assign status      = {page_q, sar_q, ssf_q, flg_q};
  assign jump_target = {page_q, addr_in};
  assign jump_take   = exec & (jmp_en | call_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      sar_q  <= 1'b0;
      ssf_q  <= 1'b0;
      skip_q <= 1'b0;
      flg_q  <= '0;
    end else if (irq_entry) begin
      ssf_q <= skip_q;
    end else if (instr_valid) begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else begin
        skip_q <= skip_take | (ret_en & sar_q);
        if (page_en)          page_q <= page_val;
        if (flag_we)          flg_q  <= flag_in;
        if (ret_en | reti_en) sar_q  <= 1'b0;
        if (st_we) begin
          page_q <= st_wdata[7:5];
          sar_q  <= st_wdata[4];
          ssf_q  <= st_wdata[3];
          flg_q  <= st_wdata[2:0];
        end
      end
    end
  end

  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && squash && !irq_entry) |=> !squash); // R5
  AST_SQUASH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && squash && !irq_entry) |=> $stable(status)); // R5
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && !squash && !irq_entry && (page_en || st_we)) |=> $stable(status[7:5])); // R2
  AST_RET_DROPS_SAR: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !squash && !irq_entry && (ret_en || reti_en) && !st_we) |=> !status[4]); // R6
  AST_IRQ_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_entry |=> (status[3] == $past(squash)) && (squash == $past(squash))); // R8
  AST_NO_TAKE_SQUASHED: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> !jump_take); // R3
endmodule

// File: tb/pgskip_ctl_bench.sv
module pgskip_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 0, page_en = 0, jmp_en = 0, call_en = 0, skip_take = 0;
  logic ret_en = 0, reti_en = 0, irq_entry = 0, st_we = 0, flag_we = 0;
  logic [2:0] page_val = '0, flag_in = '0;
  logic [12:0] addr_in = '0;
  logic [7:0] st_wdata = '0;
  logic [15:0] jump_target;
  logic jump_take, squash;
  logic [7:0] status;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  pgskip_ctl u_pgskip_ctl (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_in();
    instr_valid = 0; page_en = 0; jmp_en = 0; call_en = 0; skip_take = 0;
    ret_en = 0; reti_en = 0; irq_entry = 0; st_we = 0; flag_we = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_in();
  endtask

  task automatic wr_status(logic [7:0] v);
    instr_valid = 1; st_we = 1; st_wdata = v; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", {8'h0, status}, 16'h0);
    chk("R1 squash", {15'h0, squash}, 16'h0);
  endtask

  task automatic t_page_jump();
    instr_valid = 1; page_en = 1; page_val = 3'd5; tick();
    chk("R2 page", {8'h0, status}, 16'h00A0);
    instr_valid = 1; jmp_en = 1; addr_in = 13'h1abc; #1;
    chk("R3 target", jump_target, 16'hBABC);
    chk("R3 take", {15'h0, jump_take}, 16'h1);
    jmp_en = 0; call_en = 1; #1;
    chk("R3 call take", {15'h0, jump_take}, 16'h1);
    tick();
  endtask

  task automatic t_skip_squash();
    instr_valid = 1; skip_take = 1; tick();
    chk("R4 squash", {15'h0, squash}, 16'h1);
    tick(); tick();
    chk("R4 hold", {15'h0, squash}, 16'h1);
    instr_valid = 1; page_en = 1; page_val = 3'd2; flag_we = 1; flag_in = 3'b111;
    skip_take = 1; ret_en = 1; st_we = 1; st_wdata = 8'hFF; jmp_en = 1; #1;
    chk("R3 no take when squashed", {15'h0, jump_take}, 16'h0);
    tick();
    chk("R5 status frozen", {8'h0, status}, 16'h00A0);
    chk("R5 squash cleared", {15'h0, squash}, 16'h0);
  endtask

  task automatic t_ret();
    wr_status(8'hB0);
    chk("R9 write", {8'h0, status}, 16'h00B0);
    instr_valid = 1; ret_en = 1; tick();
    chk("R6 skip after ret", {15'h0, squash}, 16'h1);
    chk("R6 sar cleared", {8'h0, status}, 16'h00A0);
    instr_valid = 1; tick();
    instr_valid = 1; ret_en = 1; tick();
    chk("R6 no skip when sar 0", {15'h0, squash}, 16'h0);
  endtask

  task automatic t_reti();
    wr_status(8'hB0);
    instr_valid = 1; reti_en = 1; tick();
    chk("R7 no skip", {15'h0, squash}, 16'h0);
    chk("R7 sar cleared", {8'h0, status}, 16'h00A0);
  endtask

  task automatic t_irq();
    instr_valid = 1; skip_take = 1; tick();
    irq_entry = 1; instr_valid = 1; page_en = 1; page_val = 3'd3; tick();
    chk("R8 shadow set", {8'h0, status}, 16'h00A8);
    chk("R8 skip kept", {15'h0, squash}, 16'h1);
    instr_valid = 1; tick();
    chk("R8 nop absorbs", {15'h0, squash}, 16'h0);
    wr_status(8'hA0);
    chk("R9 shadow cleared", {8'h0, status}, 16'h00A0);
    irq_entry = 1; tick();
    chk("R8 shadow zero", {8'h0, status}, 16'h00A0);
  endtask

  task automatic t_flags();
    instr_valid = 1; flag_we = 1; flag_in = 3'b101; tick();
    chk("R10 flags", {8'h0, status}, 16'h00A5);
    instr_valid = 1; flag_we = 1; flag_in = 3'b010; st_we = 1; st_wdata = 8'h43;
    page_en = 1; page_val = 3'd7; tick();
    chk("R9 write wins", {8'h0, status}, 16'h0043);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_page_jump();
        t_skip_squash();
        t_ret();
        t_reti();
        t_irq();
        t_flags();
      end
      begin
        repeat (5000) @(negedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule